// File: doc/BRIEF.md
# I2C Register Target with Command Pointer

This block is the serial front end of a small register-mapped peripheral. It watches an I2C bus through two oversampled inputs (SCL and SDA, both asynchronous to the core clock) and acts as a target. It answers its own 7-bit address, which is set from pins. It also answers a broadcast address shared by many devices, so that one write reaches all of them, and the general-call address, which carries a soft-reset command.

After an address with a write bit is acknowledged, the first byte is a command. Its low nibble is kept as the register pointer, which selects one of 16 registers. Each following byte in the same write is written to the pointed register. A read sets the pointer with a short write, then issues a repeated START and the address with the read bit. The target then returns the pointed register, most significant bit first.

The register bank sits beside this block on a plain strobe port. The bank offers the selected register combinationally on `reg_rdata_i`.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: The target acknowledges its own address, given by `dev_addr_i`, with the R/W bit 0 or 1. It acknowledges by pulling SDA low (`sda_oe_o`=1) during the ninth clock.
- R2: The target does not acknowledge any address that is not its own, the broadcast address (default 68h) or the general-call address (00h). Until the next START it produces no register access.
- R3: The first byte after a write address is the command. Its bits [3:0] become the register index on `reg_idx_o`, and bits [7:4] are ignored. `reg_idx_o` is stable while `reg_wr_o` is high.
- R4: Each data byte of a write produces exactly one single-cycle `reg_wr_o` pulse. The pulse carries the byte on `reg_wdata_o` and the pointed index. The target acknowledges every command byte and data byte.
- R5: A read, sent as a repeated START plus the address with R/W=1, returns the register at the current pointer. The data is sent MSB first. `reg_rd_o` is high in the cycle in which `reg_rdata_i` is sampled, and it is never high together with `reg_wr_o`.
- R6: The number of bytes in a transfer is not limited. Extra write bytes each rewrite the same pointed register. A read continues with a fresh fetch of the same register for as long as the controller acknowledges, and it ends on a NACK.
- R7: A write to the broadcast address behaves like a write to the own address. A read on the broadcast address is not acknowledged.
- R8: A general-call write whose byte is 06h is acknowledged and produces a single-cycle `soft_reset_o` pulse. It also clears the pointer to 0. Any other general-call byte is not acknowledged and has no effect.
- R9: A STOP returns the target to idle and releases SDA. A START restarts address reception at any point, so a byte cut short by a START or STOP writes nothing. The target changes SDA only while the synchronised SCL is low.
- R10: After reset, `sda_oe_o`, `reg_wr_o`, `reg_rd_o` and `soft_reset_o` are 0 and `reg_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| dev_addr_i | input | 7 | Own target address from pins |
| reg_idx_o | output | 4 | Register pointer (command bits [3:0]) |
| reg_wr_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | 8 | Write data, valid with `reg_wr_o` |
| reg_rd_o | output | 1 | Read fetch strobe; `reg_rdata_i` is sampled in this cycle |
| reg_rdata_i | input | 8 | Data of the register selected by `reg_idx_o` |
| soft_reset_o | output | 1 | Single-cycle pulse on a general-call reset |

## Verification
A bit counter or state that is off by one shows up within one byte. The acknowledge then lands on the wrong SCL pulse, so the controller sees a NACK on the very next byte, or read data comes back shifted. A wrong pointer shows only when the data is read back. For that reason, every write is followed by a read through the port, often via the other address, and the read-back is compared with a model. A soft reset that is lost, or a pointer that is not cleared, shows on the first read that has no command byte in front of it.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int BITCNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_GCB,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_cond.sv
// Synchronises SCL/SDA and derives edge and bus-condition events.
module i2c_tgt_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_q;
  logic [MSB:0] sda_q;
  logic         scl_p;
  logic         sda_p;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[MSB-1:0], scl_i};
          sda_q <= {sda_q[MSB-1:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_q[MSB];
      sda_p <= sda_q[MSB];
    end
  end

  assign scl_s     = scl_q[MSB];
  assign sda_s     = sda_q[MSB];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tgt_addr_dec.sv
// Classifies a received address byte.
module i2c_tgt_addr_dec
  import i2c_tgt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ALLCALL_ADDR = 7'h68,
  parameter logic [ADDR_W-1:0] GENCALL_ADDR = 7'h00
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              hit_own,
  output logic              hit_all,
  output logic              hit_gen,
  output logic              is_read
);
  logic [ADDR_W-1:0] addr;

  assign addr    = byte_i[BYTE_W-1:1];
  assign is_read = byte_i[0];
  assign hit_own = (addr == dev_addr_i);
  assign hit_all = (addr == ALLCALL_ADDR);
  assign hit_gen = (addr == GENCALL_ADDR);
endmodule

// File: rtl/i2c_tgt_fsm.sv
// Byte/bit protocol engine: address, command, write, read, soft reset.
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int                IDX_W      = 4,
  parameter logic [BYTE_W-1:0] RESET_BYTE = 8'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              hit_own,
  input  logic              hit_all,
  input  logic              hit_gen,
  input  logic              is_read,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sda_drv,
  output logic [IDX_W-1:0]  ptr,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wdata,
  output logic              rd_stb,
  input  logic [BYTE_W-1:0] rdata,
  output logic              swrst
);
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);

  tgt_state_e          state, state_n, after, after_n;
  logic [BITCNT_W-1:0] cnt, cnt_n;
  logic [BYTE_W-1:0]   sr, sr_n, tx, tx_n, wdata_n;
  logic [IDX_W-1:0]    ptr_n;
  logic                drv_n, mack, mack_n, wr_n, swrst_n;
  logic                rx_state, byte_end;

  assign rx_byte  = sr;
  assign rx_state = (state == ST_ADDR) || (state == ST_CMD) ||
                    (state == ST_WDATA) || (state == ST_GCB);
  assign byte_end = scl_fall && (cnt == LAST_BIT);

  always_comb begin
    state_n = state;
    after_n = after;
    cnt_n   = cnt;
    sr_n    = sr;
    tx_n    = tx;
    ptr_n   = ptr;
    drv_n   = sda_drv;
    mack_n  = mack;
    wdata_n = wdata;
    wr_n    = 1'b0;
    rd_stb  = 1'b0;
    swrst_n = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE;
      drv_n   = 1'b0;
    end else if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      drv_n   = 1'b0;
    end else if (rx_state) begin
      if (scl_rise) begin
        sr_n  = {sr[BYTE_W-2:0], sda_s};
        cnt_n = cnt + 1'b1;
      end else if (byte_end) begin
        cnt_n   = '0;
        state_n = ST_IDLE;
        case (state)
          ST_ADDR: begin
            if (hit_own) begin
              drv_n = 1'b1; state_n = ST_ACK;
              after_n = is_read ? ST_TX : ST_CMD;
            end else if (hit_all && !is_read) begin
              drv_n = 1'b1; state_n = ST_ACK; after_n = ST_CMD;
            end else if (hit_gen && !is_read) begin
              drv_n = 1'b1; state_n = ST_ACK; after_n = ST_GCB;
            end
          end
          ST_CMD: begin
            ptr_n = sr[IDX_W-1:0];
            drv_n = 1'b1; state_n = ST_ACK; after_n = ST_WDATA;
          end
          ST_WDATA: begin
            wr_n = 1'b1; wdata_n = sr;
            drv_n = 1'b1; state_n = ST_ACK; after_n = ST_WDATA;
          end
          default: begin
            if (sr == RESET_BYTE) begin
              swrst_n = 1'b1; ptr_n = '0;
              drv_n = 1'b1; state_n = ST_ACK; after_n = ST_IDLE;
            end
          end
        endcase
      end
    end else begin
      case (state)
        ST_ACK: if (scl_fall) begin
          drv_n   = 1'b0;
          state_n = after;
          cnt_n   = '0;
          if (after == ST_TX) begin
            rd_stb = 1'b1; tx_n = rdata; drv_n = ~rdata[BYTE_W-1];
          end
        end
        ST_TX: begin
          if (scl_rise) cnt_n = cnt + 1'b1;
          else if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              drv_n = 1'b0; state_n = ST_TXACK;
            end else begin
              tx_n  = {tx[BYTE_W-2:0], 1'b0};
              drv_n = ~tx[BYTE_W-2];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) mack_n = ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              state_n = ST_TX; cnt_n = '0;
              rd_stb = 1'b1; tx_n = rdata; drv_n = ~rdata[BYTE_W-1];
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      after   <= ST_IDLE;
      cnt     <= '0;
      sr      <= '0;
      tx      <= '0;
      ptr     <= '0;
      sda_drv <= 1'b0;
      mack    <= 1'b0;
      wdata   <= '0;
      wr_stb  <= 1'b0;
      swrst   <= 1'b0;
    end else begin
      state   <= state_n;
      after   <= after_n;
      cnt     <= cnt_n;
      sr      <= sr_n;
      tx      <= tx_n;
      ptr     <= ptr_n;
      sda_drv <= drv_n;
      mack    <= mack_n;
      wdata   <= wdata_n;
      wr_stb  <= wr_n;
      swrst   <= swrst_n;
    end
  end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
// Top: I2C register target with command pointer.
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int                REG_COUNT    = 16,
  parameter int                SYNC_STAGES  = 2,
  parameter logic [ADDR_W-1:0] ALLCALL_ADDR = 7'h68,
  parameter logic [BYTE_W-1:0] RESET_BYTE   = 8'h06,
  localparam int               IDX_W        = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic              reg_wr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              soft_reset_o
);
  logic [1:0]        rst_q;
  logic              rst_sync_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              hit_own, hit_all, hit_gen, is_read;
  logic [BYTE_W-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  i2c_tgt_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_addr_dec #(.ALLCALL_ADDR(ALLCALL_ADDR)) u_dec (
    .byte_i(rx_byte), .dev_addr_i(dev_addr_i),
    .hit_own(hit_own), .hit_all(hit_all), .hit_gen(hit_gen), .is_read(is_read)
  );

  i2c_tgt_fsm #(.IDX_W(IDX_W), .RESET_BYTE(RESET_BYTE)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .hit_own(hit_own), .hit_all(hit_all), .hit_gen(hit_gen), .is_read(is_read),
    .rx_byte(rx_byte), .sda_drv(sda_oe_o), .ptr(reg_idx_o),
    .wr_stb(reg_wr_o), .wdata(reg_wdata_o),
    .rd_stb(reg_rd_o), .rdata(reg_rdata_i), .swrst(soft_reset_o)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
// Protocol checker attached to the top module.
module i2c_tgt_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_oe_o,
  input logic             reg_wr_o,
  input logic             reg_rd_o,
  input logic [IDX_W-1:0] reg_idx_o,
  input logic             soft_reset_o
);
  p_sda_moves_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_o) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

  p_stop_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);

  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  p_rd_wr_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o));

  p_idx_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> $stable(reg_idx_o));

  p_swrst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_o |=> !soft_reset_o);
endmodule

bind i2c_tgt_ctrl i2c_tgt_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe_o(sda_oe_o), .reg_wr_o(reg_wr_o),
  .reg_rd_o(reg_rd_o), .reg_idx_o(reg_idx_o), .soft_reset_o(soft_reset_o)
);

// File: tb/i2c_tgt_ctrl_tb.sv
module i2c_tgt_ctrl_tb;
  localparam int H = 10;
  localparam logic [6:0] OWN = 7'h24;
  localparam logic [6:0] ALL = 7'h68;
  localparam logic [6:0] OTHER = 7'h25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, reg_wr, reg_rd, soft_rst;
  logic [3:0] reg_idx;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_line;
  logic [7:0] bank [16];
  logic [7:0] exp_bank [16];
  int n_tests = 0, n_fail = 0, wr_cnt = 0, rst_cnt = 0, rd_cnt = 0, oe_bad = 0;
  logic oe_prev = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;
  assign reg_rdata = bank[reg_idx];

  i2c_tgt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .dev_addr_i(OWN), .reg_idx_o(reg_idx),
    .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata), .reg_rd_o(reg_rd),
    .reg_rdata_i(reg_rdata), .soft_reset_o(soft_rst)
  );

  function automatic logic [7:0] dflt(input int i);
    return 8'(i * 17);
  endfunction

  function automatic logic [3:0] sel(input logic [7:0] cmd);
    return cmd[3:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) bank[i] <= dflt(i);
    end else if (reg_wr) begin
      bank[reg_idx] <= reg_wdata;
    end
    if (reg_wr) wr_cnt++;
    if (reg_rd) rd_cnt++;
    if (soft_rst) rst_cnt++;
    if (sda_oe != oe_prev && scl_m) oe_bad++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic hw(); repeat (H) @(negedge clk); endtask

  task automatic i_start();
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic i_stop();
    sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; hw(); scl_m = 1'b1;
    repeat (H / 2) @(negedge clk);
    ack = ~sda_line;
    repeat (H / 2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); scl_m = 1'b1;
      repeat (H / 2) @(negedge clk);
      d[i] = sda_line;
      repeat (H / 2) @(negedge clk);
      scl_m = 1'b0;
    end
    sda_m = ~mack; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0;
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] cmd,
                        input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    i_start();
    send_byte({a, 1'b0}, a0);
    send_byte(cmd, a1);
    send_byte(d, a2);
    i_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic rd_reg(input logic [6:0] a, input logic [7:0] cmd,
                        output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    i_start();
    send_byte({a, 1'b0}, a0);
    send_byte(cmd, a1);
    i_start();
    send_byte({a, 1'b1}, a2);
    if (a2) recv_byte(d, 1'b0); else d = 8'hxx;
    i_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ok, ak;
    logic [7:0] d, d2, cmd, val;
    int w0, r0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) exp_bank[i] = dflt(i);
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10 sda_oe", 32'(sda_oe), 0);
    chk("R10 wr/rd/rst", {reg_wr, reg_rd, soft_rst}, 0);
    chk("R10 idx", 32'(reg_idx), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R4 own-address write then read
    w0 = wr_cnt;
    wr_reg(OWN, 8'h03, 8'hA5, ok); exp_bank[3] = 8'hA5;
    chk("R1 R4 acks", 32'(ok), 1);
    chk("R4 one write", wr_cnt - w0, 1);
    r0 = rd_cnt;
    rd_reg(OWN, 8'h03, d, ok);
    chk("R5 read acks", 32'(ok), 1);
    chk("R5 read data", 32'(d), 32'(exp_bank[3]));
    chk("R5 one fetch", rd_cnt - r0, 1);

    // R3 high nibble ignored
    wr_reg(OWN, 8'hF5, 8'h3C, ok); exp_bank[sel(8'hF5)] = 8'h3C;
    rd_reg(OWN, 8'h05, d, ok);
    chk("R3 low nibble selects", 32'(d), 32'h3C);

    // R2 other address
    w0 = wr_cnt;
    i_start(); send_byte({OTHER, 1'b0}, ak);
    chk("R2 no ack", 32'(ak), 0);
    send_byte(8'h03, ak); send_byte(8'h00, ak); i_stop();
    chk("R2 no write", wr_cnt - w0, 0);
    rd_reg(OWN, 8'h03, d, ok);
    chk("R2 reg kept", 32'(d), 32'(exp_bank[3]));

    // R7 all-call write and read
    wr_reg(ALL, 8'h0C, 8'h81, ok); exp_bank[12] = 8'h81;
    chk("R7 all-call write ack", 32'(ok), 1);
    rd_reg(OWN, 8'h0C, d, ok);
    chk("R7 all-call data", 32'(d), 32'h81);
    i_start(); send_byte({ALL, 1'b1}, ak); i_stop();
    chk("R7 all-call read nack", 32'(ak), 0);

    // R6 multi-byte write and read
    w0 = wr_cnt;
    i_start(); send_byte({OWN, 1'b0}, ak); send_byte(8'h07, ak);
    send_byte(8'h11, ak); send_byte(8'h22, ak); send_byte(8'h33, ak);
    i_stop(); exp_bank[7] = 8'h33;
    chk("R6 three writes", wr_cnt - w0, 3);
    chk("R6 last ack", 32'(ak), 1);
    i_start(); send_byte({OWN, 1'b0}, ak); send_byte(8'h07, ak);
    i_start(); send_byte({OWN, 1'b1}, ak);
    recv_byte(d, 1'b1); recv_byte(d2, 1'b0); i_stop();
    chk("R6 burst read 1", 32'(d), 32'h33);
    chk("R6 burst read 2", 32'(d2), 32'h33);

    // R8 soft reset
    i_start(); send_byte(8'h00, ak);
    chk("R8 gencall addr ack", 32'(ak), 1);
    send_byte(8'h06, ak); i_stop();
    chk("R8 reset byte ack", 32'(ak), 1);
    chk("R8 one pulse", rst_cnt, 1);
    i_start(); send_byte({OWN, 1'b1}, ak); recv_byte(d, 1'b0); i_stop();
    chk("R8 pointer cleared", 32'(d), 32'(exp_bank[0]));
    i_start(); send_byte(8'h00, ak); send_byte(8'h07, ak); i_stop();
    chk("R8 other byte nack", 32'(ak), 0);
    chk("R8 no pulse", rst_cnt, 1);

    // R9 byte cut by STOP, and by repeated START
    w0 = wr_cnt;
    i_start(); send_byte({OWN, 1'b0}, ak); send_byte(8'h02, ak);
    send_bits(8'hF0, 4); scl_m = 1'b0; hw(); i_stop();
    chk("R9 cut byte no write", wr_cnt - w0, 0);
    chk("R9 sda released", 32'(sda_oe), 0);
    i_start(); send_byte({OWN, 1'b0}, ak); send_byte(8'h09, ak);
    i_start(); send_byte({OWN, 1'b0}, ak); send_byte(8'h0A, ak);
    send_byte(8'h55, ak); i_stop(); exp_bank[10] = 8'h55;
    chk("R9 restart write count", wr_cnt - w0, 1);
    rd_reg(OWN, 8'h09, d, ok);
    chk("R9 reg 9 untouched", 32'(d), 32'(exp_bank[9]));
    rd_reg(OWN, 8'h0A, d, ok);
    chk("R9 reg A written", 32'(d), 32'h55);

    // R4 R5 random traffic
    for (int k = 0; k < 20; k++) begin
      cmd = 8'($urandom); val = 8'($urandom);
      wr_reg(($urandom % 2) ? ALL : OWN, cmd, val, ok);
      exp_bank[sel(cmd)] = val;
      chk("R4 random write ack", 32'(ok), 1);
      cmd = 8'($urandom);
      rd_reg(OWN, cmd, d, ok);
      chk("R5 random read", 32'(d), 32'(exp_bank[sel(cmd)]));
    end

    chk("R9 sda only moves with scl low", oe_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule